// File: doc/BRIEF.md
# Gate Driver Controller-Side Control Logic

This block is the clocked logic on the low-voltage side of an isolated power-switch gate driver. It receives a non-inverting and an inverting PWM input, an active-low clear input, two supply-good flags (controller side and power side), and a fault indication that arrives from the power side. It produces the gate command sent toward the output stage, a ready flag, and an active-low fault flag. The fault flag is modelled as an open-drain pull-down enable plus the level the pin would show with a pull-up.

Each of the three control inputs passes through a counting glitch filter, with lengths given in clock cycles. The gate command is the AND of the filtered inputs, both supply flags and the absence of a latched fault. A power-side fault sets a latch that blocks the gate command. Only a filtered low pulse on the clear input, taken while ready is high, releases the latch. The flag read-back can be wired into the non-inverting input so that the driver shuts itself down on a fault.

Top module: `gd_input_ctrl`

## Requirements
- R1: One clock after the filtered non-inverting input is high, the filtered inverting input is low, the filtered clear input is high, both supply flags are high and no fault is latched or arriving, `gate_cmd_o` is 1. In every other case it is 0.
- R2: `ready_o` equals the AND of `supply_ctl_ok_i` and `supply_pwr_ok_i` as sampled on the previous clock edge.
- R3: On the clock edge after either supply flag is sampled low, `gate_cmd_o` is 0, whatever the PWM and clear inputs are.
- R4: A filtered input takes a new raw value only after the raw value has differed from it on FLT_IN_CYC consecutive edges (FLT_CLR_CYC for the clear input). A shorter excursion on a PWM input leaves `gate_cmd_o` unchanged.
- R5: A 1 on `pwr_fault_i` sampled at an edge sets the fault latch at that edge. `fault_pull_o` becomes 1, `fault_level_o` becomes 0 and `gate_cmd_o` becomes 0.
- R6: A latched fault clears at the first edge where the filtered clear input is low and `ready_o` is 1. A clear pulse shorter than FLT_CLR_CYC cycles does not clear it.
- R7: While `ready_o` is 0, a latched fault stays set even if a valid clear pulse is present.
- R8: When a fault is sampled on the same edge that a clear would take effect, the latch stays set.
- R9: A filtered-low clear input forces `gate_cmd_o` to 0 even when no fault is latched.
- R10: During and right after reset, `gate_cmd_o`=0, `ready_o`=0, `fault_pull_o`=0 and `fault_level_o`=1.
- R11: With `fault_level_o` ANDed into the non-inverting input, a fault holds the gate command low until the latch is cleared. After that, switching resumes without any other action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_pos_i | input | 1 | Non-inverting PWM input (raw) |
| pwm_neg_i | input | 1 | Inverting PWM input (raw) |
| clr_n_i | input | 1 | Active-low fault clear and gate enable (raw) |
| supply_ctl_ok_i | input | 1 | Controller-side supply good |
| supply_pwr_ok_i | input | 1 | Power-side supply good |
| pwr_fault_i | input | 1 | Fault indication from the power side |
| gate_cmd_o | output | 1 | Gate command toward the output stage |
| ready_o | output | 1 | Both supplies good |
| fault_pull_o | output | 1 | Pull-down enable of the active-low fault pin |
| fault_level_o | output | 1 | Fault pin level with pull-up (0 = fault) |

## Verification
The bench builds the block with FLT_IN_CYC=3 and FLT_CLR_CYC=8. These values are short enough that PWM glitches of one and two cycles, clear pulses one cycle under the minimum, and long clear pulses all fit into a few thousand random cycles. The fault latch therefore sets and clears many times, both with ready high and with ready low. At the defaults, the 40-cycle clear window would rarely be met by random holds.

// File: rtl/gd_ctrl_pkg.sv
package gd_ctrl_pkg;
    // Index of each filtered control input
    localparam int unsigned IDX_POS = 0;
    localparam int unsigned IDX_NEG = 1;
    localparam int unsigned IDX_CLR = 2;
    localparam int unsigned N_CTRL  = 3;

    typedef struct packed {
        logic ready;
        logic gate;
    } gd_out_st_t;

    typedef struct packed {
        logic latched;
    } gd_fault_st_t;
endpackage

// File: rtl/gd_glitch_filter.sv
module gd_glitch_filter #(
    parameter int unsigned LEN  = 2,
    parameter bit          INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int unsigned CW   = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    typedef struct packed {
        logic          filt;
        logic [CW-1:0] cnt;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raw_i == st_q.filt) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.filt = raw_i;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.filt <= INIT;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt_o = st_q.filt;

    // R4
    filt_follows_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.filt != $past(st_q.filt)) |-> ($past(raw_i) == st_q.filt));

    // R4
    filt_cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_i == st_q.filt) |=> (st_q.cnt == '0));
endmodule

// File: rtl/gd_fault_latch.sv
module gd_fault_latch
    import gd_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_req_i,
    input  logic ready_i,
    output logic fault_o,
    output logic fault_nxt_o
);
    gd_fault_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.latched = 1'b1;
        end else if (st_q.latched && clr_req_i && ready_i) begin
            st_d.latched = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fault_o     = st_q.latched;
    assign fault_nxt_o = st_d.latched;

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> st_q.latched);

    // R7
    hold_unready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.latched && !ready_i) |=> st_q.latched);

    // R6
    clear_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.latched) |-> $past(clr_req_i && ready_i));
endmodule

// File: rtl/gd_input_ctrl.sv
module gd_input_ctrl
    import gd_ctrl_pkg::*;
#(
    parameter int unsigned FLT_IN_CYC  = 2,
    parameter int unsigned FLT_CLR_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_pos_i,
    input  logic pwm_neg_i,
    input  logic clr_n_i,
    input  logic supply_ctl_ok_i,
    input  logic supply_pwr_ok_i,
    input  logic pwr_fault_i,
    output logic gate_cmd_o,
    output logic ready_o,
    output logic fault_pull_o,
    output logic fault_level_o
);
    logic [N_CTRL-1:0] raw_ctrl;
    logic [N_CTRL-1:0] filt_ctrl;
    logic              fault_q;
    logic              fault_nxt;
    logic              supplies_ok;
    gd_out_st_t        out_d, out_q;

    assign raw_ctrl[IDX_POS] = pwm_pos_i;
    assign raw_ctrl[IDX_NEG] = pwm_neg_i;
    assign raw_ctrl[IDX_CLR] = clr_n_i;

    for (genvar g = 0; g < N_CTRL; g++) begin : g_filt
        localparam int unsigned LEN  = (g == IDX_CLR) ? FLT_CLR_CYC : FLT_IN_CYC;
        localparam bit          INIT = (g == IDX_NEG) ? 1'b1 : 1'b0;
        gd_glitch_filter #(.LEN(LEN), .INIT(INIT)) i_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_ctrl[g]),
            .filt_o(filt_ctrl[g])
        );
    end

    gd_fault_latch i_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (pwr_fault_i),
        .clr_req_i  (!filt_ctrl[IDX_CLR]),
        .ready_i    (out_q.ready),
        .fault_o    (fault_q),
        .fault_nxt_o(fault_nxt)
    );

    assign supplies_ok = supply_ctl_ok_i && supply_pwr_ok_i;

    always_comb begin
        out_d       = out_q;
        out_d.ready = supplies_ok;
        out_d.gate  = filt_ctrl[IDX_POS] && !filt_ctrl[IDX_NEG] && filt_ctrl[IDX_CLR]
                      && supplies_ok && !fault_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign gate_cmd_o    = out_q.gate;
    assign ready_o       = out_q.ready;
    assign fault_pull_o  = fault_q;
    assign fault_level_o = !fault_q;

    // R3
    supply_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(supply_ctl_ok_i && supply_pwr_ok_i) |=> !gate_cmd_o);

    // R2
    ready_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ready_o == $past(supply_ctl_ok_i && supply_pwr_ok_i)));

    // R1
    gate_blocked_by_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_cmd_o |-> !fault_pull_o);

    // R5
    fault_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fault_i |=> (fault_pull_o && !fault_level_o && !gate_cmd_o));

    // R9
    gate_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !filt_ctrl[IDX_CLR] |=> !gate_cmd_o);
endmodule

// File: tb/test_gd_input_ctrl.sv
module test_gd_input_ctrl;
    localparam int P_IN  = 3;
    localparam int P_CLR = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pos_raw = 1'b0, neg = 1'b1, clr_n = 1'b1;
    logic ok_ctl = 1'b0, ok_pwr = 1'b0, flt_in = 1'b0, tie = 1'b0;
    logic pos_in;
    logic gate, rdy, fpull, flevel;
    int   checks = 0, errors = 0, cycles = 0;
    bit   cmp_on = 1'b0;

    always #10 clk = ~clk;

    assign pos_in = tie ? (pos_raw & flevel) : pos_raw;

    gd_input_ctrl #(.FLT_IN_CYC(P_IN), .FLT_CLR_CYC(P_CLR)) i_gd_input_ctrl (
        .clk(clk), .rst_n(rst_n), .pwm_pos_i(pos_in), .pwm_neg_i(neg),
        .clr_n_i(clr_n), .supply_ctl_ok_i(ok_ctl), .supply_pwr_ok_i(ok_pwr),
        .pwr_fault_i(flt_in), .gate_cmd_o(gate), .ready_o(rdy),
        .fault_pull_o(fpull), .fault_level_o(flevel)
    );

    // Reference model built from the requirements
    bit m_f[3];
    int m_c[3];
    bit m_gate, m_ready, m_fault;

    function automatic bit f_val(bit raw, bit f, int c, int len);
        if (raw != f && c == len - 1) return raw;
        return f;
    endfunction
    function automatic int f_cnt(bit raw, bit f, int c, int len);
        if (raw == f || c == len - 1) return 0;
        return c + 1;
    endfunction
    function automatic bit fault_next(bit fin, bit fq, bit clr_f, bit rdyq);
        return fin || (fq && !(!clr_f && rdyq));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_f[0] <= 1'b0; m_f[1] <= 1'b1; m_f[2] <= 1'b0;
            m_c[0] <= 0; m_c[1] <= 0; m_c[2] <= 0;
            m_gate <= 1'b0; m_ready <= 1'b0; m_fault <= 1'b0;
        end else begin
            bit fn;
            fn = fault_next(flt_in, m_fault, m_f[2], m_ready);
            m_gate  <= m_f[0] && !m_f[1] && m_f[2] && ok_ctl && ok_pwr && !fn;
            m_ready <= ok_ctl && ok_pwr;
            m_fault <= fn;
            m_f[0] <= f_val(pos_in, m_f[0], m_c[0], P_IN);
            m_c[0] <= f_cnt(pos_in, m_f[0], m_c[0], P_IN);
            m_f[1] <= f_val(neg, m_f[1], m_c[1], P_IN);
            m_c[1] <= f_cnt(neg, m_f[1], m_c[1], P_IN);
            m_f[2] <= f_val(clr_n, m_f[2], m_c[2], P_CLR);
            m_c[2] <= f_cnt(clr_n, m_f[2], m_c[2], P_CLR);
        end
    end

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            check(gate == m_gate, "R1 gate vs model", gate, m_gate);
            check(rdy == m_ready, "R2 ready vs model", rdy, m_ready);
            check(fpull == m_fault && flevel == !m_fault, "R5 fault vs model", fpull, m_fault);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        tick(3);
        // R10 reset state
        check(gate == 0 && rdy == 0, "R10 gate/ready in reset", {gate, rdy}, 0);
        check(fpull == 0 && flevel == 1, "R10 fault pin in reset", {fpull, flevel}, 1);
        rst_n = 1'b1;
        tick(1);
        check(gate == 0 && rdy == 0 && fpull == 0 && flevel == 1, "R10 after release",
              {gate, rdy, fpull, flevel}, 1);
        cmp_on = 1'b1;

        ok_ctl = 1; ok_pwr = 1; neg = 0; pos_raw = 1; clr_n = 1;
        tick(20);
        check(gate == 1, "R1 gate on", gate, 1);
        check(rdy == 1, "R2 ready on", rdy, 1);

        pos_raw = 0; tick(P_IN - 1); pos_raw = 1; tick(5);
        check(gate == 1, "R4 pos glitch ignored", gate, 1);
        neg = 1; tick(P_IN - 1); neg = 0; tick(5);
        check(gate == 1, "R4 neg glitch ignored", gate, 1);
        neg = 1; tick(6);
        check(gate == 0, "R1 inverting high", gate, 0);
        neg = 0; tick(6);
        check(gate == 1, "R1 inverting low again", gate, 1);

        ok_pwr = 0; tick(1);
        check(gate == 0, "R3 power supply loss", gate, 0);
        ok_pwr = 1; tick(6);
        ok_ctl = 0; tick(1);
        check(gate == 0, "R3 control supply loss", gate, 0);
        ok_ctl = 1; tick(6);
        check(gate == 1, "R1 restored", gate, 1);

        flt_in = 1; tick(1); flt_in = 0;
        check(fpull == 1 && flevel == 0 && gate == 0, "R5 fault set", {fpull, flevel, gate}, 4);
        tick(5);
        check(fpull == 1, "R5 fault held", fpull, 1);

        clr_n = 0; tick(P_CLR - 1); clr_n = 1; tick(10);
        check(fpull == 1, "R6 short clear ignored", fpull, 1);

        ok_ctl = 0; tick(2); clr_n = 0; tick(12);
        check(fpull == 1, "R7 held while not ready", fpull, 1);
        ok_ctl = 1; tick(3);
        check(fpull == 0, "R6 cleared once ready", fpull, 0);
        clr_n = 1; tick(12);
        check(gate == 1, "R1 running after clear", gate, 1);

        clr_n = 0; tick(10);
        check(gate == 0, "R9 clear low blocks gate", gate, 0);
        clr_n = 1; tick(12);

        flt_in = 1; clr_n = 0; tick(12);
        check(fpull == 1, "R8 fault wins over clear", fpull, 1);
        flt_in = 0; tick(2);
        check(fpull == 0, "R8 clears after fault drops", fpull, 0);
        clr_n = 1; tick(12);

        tie = 1; tick(8);
        check(gate == 1, "R11 tied mode running", gate, 1);
        flt_in = 1; tick(1); flt_in = 0; tick(10);
        check(gate == 0 && fpull == 1, "R11 shutdown on fault", {gate, fpull}, 1);
        clr_n = 0; tick(12);
        check(fpull == 0, "R11 latch cleared", fpull, 0);
        clr_n = 1; tick(15);
        check(gate == 1, "R11 resumes", gate, 1);
        tie = 0;

        for (int i = 0; i < 900; i++) begin
            pos_raw = $urandom_range(0, 1);
            neg     = ($urandom_range(0, 3) == 0);
            clr_n   = ($urandom_range(0, 5) != 0);
            ok_ctl  = ($urandom_range(0, 9) != 0);
            ok_pwr  = ($urandom_range(0, 9) != 0);
            flt_in  = ($urandom_range(0, 15) == 0);
            tie     = ($urandom_range(0, 7) == 0);
            tick($urandom_range(1, 12));
        end
        flt_in = 0;
        tick(2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule